// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block generates the reset line for a processor from two independent causes. A digital flag from an external comparator reports whether the supply is above its trip level. A watchdog expects periodic high-to-low transitions on a shared chip-select/watchdog-kick pin. The reset is asserted while the supply is below trip, and whenever the kick pin keeps one level for longer than the selected watchdog period. Once the cause has gone, reset stays asserted for a fixed hold delay, so the processor restarts from a known state.

Both asynchronous inputs pass through a two-stage synchronizer, and all edge detection uses the synchronized values. The hold delay and the three watchdog periods are parameters counted in clock ticks. A two-bit select picks the active period or turns the watchdog off. The reset output is modelled as an open-drain pin, with a drive enable and a driven level. A parameter sets the polarity of the driven level.

Top module: `sup_wdog_supervisor`

## Requirements
- R1: While `rst` is high, the reset output is driven (`rst_drive_o` = 1) at its active level.
- R2: Suppose `supply_ok_i` is already 1 when `rst` falls, and call the first rising edge with `rst` low edge 1. Reset is then released on edge HOLD_TICKS+2.
- R3: If `supply_ok_i` is 0 at edge U, reset is asserted after edge U+2 and not before.
- R4: Let edge U be the first edge that samples `supply_ok_i` back at 1 after a loss. Reset is released on edge U+HOLD_TICKS+1. A loss during the hold delay restarts the count.
- R5: With the watchdog enabled, suppose no high-to-low transition of `wdi_i` occurs. Reset then asserts exactly P edges after the watchdog starts counting, with P being the selected period. The start is the release of reset or the switch to an enabled period. This holds whether the pin stays high or stays low.
- R6: Suppose `wdi_i` first samples 0 after a 1 at edge t. The count is then cleared on edge t+2, and the timeout moves to edge t+2+P. A low-to-high transition does not clear the count, and kicks spaced less than P-3 edges apart keep reset released.
- R7: `period_sel_i` encodes 00 = PERIOD_LONG, 01 = PERIOD_MID, 10 = PERIOD_SHORT, and 11 = watchdog disabled. When disabled, no timeout occurs.
- R8: A watchdog timeout that asserts reset on edge B releases it on edge B+HOLD_TICKS. The watchdog count then starts again from zero.
- R9: While reset is driven, `rst_level_o` equals ACTIVE_HIGH. While released, `rst_drive_o` is 0 and `rst_level_o` is the inverse of ACTIVE_HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power application) |
| supply_ok_i | input | 1 | Comparator flag, 1 = supply above trip (asynchronous) |
| wdi_i | input | 1 | Chip-select/watchdog-kick pin (asynchronous) |
| period_sel_i | input | 2 | Watchdog period select |
| rst_level_o | output | 1 | Level of the reset pin when driven |
| rst_drive_o | output | 1 | Open-drain drive enable, 1 = reset asserted |

## Verification
All input changes take place on the falling clock edge, and a free-running edge counter timestamps each change. For each result the bench computes the edge on which it is due from the requirement's latency formula:

| Result | Due on edge |
|---|---|
| Supply-loss assertion | +3 |
| Recovery release | +HOLD_TICKS+2 |
| Timeout after the watchdog starts | +P |
| Timeout after a kick | +3+P |
| Release after a timeout | +HOLD_TICKS |

The bench polls the outputs at falling edges and compares the edge count at the change with the expected value. It therefore catches a change that comes one cycle early or one cycle late. For the supply-loss case it also checks that the output has not yet changed one cycle before the due edge.

// File: rtl/sup_wdog_pkg.sv
package sup_wdog_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic supply_ok;
        logic wdi;
    } pins_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned wd_period(input wd_sel_e s, input int unsigned p_long,
                                              input int unsigned p_mid,
                                              input int unsigned p_short);
        case (s)
            WD_LONG: return p_long;
            WD_MID:  return p_mid;
            default: return p_short;
        endcase
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[gi] <= '0;
                else     stg[gi] <= stg[gi-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
    parameter int unsigned HOLD_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_s,
    input  logic wd_bite,
    output logic active
);
    localparam int HCW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [HCW-1:0] LAST = HCW'(HOLD_TICKS - 1);

    logic [HCW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (!supply_s || wd_bite) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> active); // R3

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt) == LAST && $past(supply_s))); // R4
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_wdog_pkg::*;
#(
    parameter int unsigned PERIOD_LONG  = 40,
    parameter int unsigned PERIOD_MID   = 24,
    parameter int unsigned PERIOD_SHORT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wdi_s,
    input  logic [1:0] sel,
    input  logic       hold_active,
    output logic       bite
);
    localparam int unsigned MAXP = max3(PERIOD_LONG, PERIOD_MID, PERIOD_SHORT);
    localparam int WCW = $clog2(MAXP);

    wd_sel_e        sel_e;
    logic           wdi_prev;
    logic           fall;
    logic [WCW-1:0] wcnt;
    logic [WCW-1:0] lim_m1;

    assign sel_e  = wd_sel_e'(sel);
    assign fall   = wdi_prev && !wdi_s;
    assign lim_m1 = WCW'(wd_period(sel_e, PERIOD_LONG, PERIOD_MID, PERIOD_SHORT) - 1);
    assign bite   = (sel_e != WD_OFF) && !hold_active && !fall && (wcnt >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wdi_prev <= 1'b0;
            wcnt     <= '0;
        end else begin
            wdi_prev <= wdi_s;
            if (hold_active || sel_e == WD_OFF || fall || bite) wcnt <= '0;
            else                                                  wcnt <= wcnt + 1'b1;
        end
    end

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wdi_prev && !wdi_s) |=> (wcnt == '0)); // R6

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b11) |=> (wcnt == '0)); // R7
endmodule

// File: rtl/sup_wdog_supervisor.sv
module sup_wdog_supervisor
    import sup_wdog_pkg::*;
#(
    parameter int unsigned HOLD_TICKS   = 20_000_000,
    parameter int unsigned PERIOD_LONG  = 140_000_000,
    parameter int unsigned PERIOD_MID   = 60_000_000,
    parameter int unsigned PERIOD_SHORT = 20_000_000,
    parameter bit          ACTIVE_HIGH  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       wdi_i,
    input  logic [1:0] period_sel_i,
    output logic       rst_level_o,
    output logic       rst_drive_o
);
    pins_t raw_pins;
    pins_t sync_pins;
    logic  wd_bite;
    logic  hold_active;

    assign raw_pins.supply_ok = supply_ok_i;
    assign raw_pins.wdi       = wdi_i;

    sup_sync #(.W($bits(pins_t)), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    sup_wdog #(
        .PERIOD_LONG  (PERIOD_LONG),
        .PERIOD_MID   (PERIOD_MID),
        .PERIOD_SHORT (PERIOD_SHORT)
    ) u_wdog (
        .clk         (clk),
        .rst         (rst),
        .wdi_s       (sync_pins.wdi),
        .sel         (period_sel_i),
        .hold_active (hold_active),
        .bite        (wd_bite)
    );

    sup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .supply_s (sync_pins.supply_ok),
        .wd_bite  (wd_bite),
        .active   (hold_active)
    );

    assign rst_drive_o = hold_active;
    assign rst_level_o = hold_active ? ACTIVE_HIGH : !ACTIVE_HIGH;

    AST_BITE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        wd_bite |=> rst_drive_o); // R5

    AST_RST_DRIVEN: assert property (@(posedge clk)
        rst |=> rst_drive_o); // R1
endmodule

// File: tb/sup_wdog_supervisor_tb.sv
`timescale 1ns/1ps
module sup_wdog_supervisor_tb;
    localparam int HOLD = 20;
    localparam int PL   = 40;
    localparam int PM   = 24;
    localparam int PS   = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b1;
    logic       wdi = 1'b1;
    logic [1:0] sel = 2'b11;
    logic       lvl, drv, lvl_hi, drv_hi;
    int         cyc = 0;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sup_wdog_supervisor #(.HOLD_TICKS(HOLD), .PERIOD_LONG(PL), .PERIOD_MID(PM),
                          .PERIOD_SHORT(PS), .ACTIVE_HIGH(1'b0)) u_dut (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .wdi_i(wdi),
        .period_sel_i(sel), .rst_level_o(lvl), .rst_drive_o(drv));

    sup_wdog_supervisor #(.HOLD_TICKS(HOLD), .PERIOD_LONG(PL), .PERIOD_MID(PM),
                          .PERIOD_SHORT(PS), .ACTIVE_HIGH(1'b1)) u_dut_hi (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .wdi_i(wdi),
        .period_sel_i(sel), .rst_level_o(lvl_hi), .rst_drive_o(drv_hi));

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_drive(input logic want, output int at);
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (drv == want) begin
                at = cyc;
                return;
            end
        end
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 drive in reset", int'(drv), 1);
        chk("R1 level in reset", int'(lvl), 0);
        chk("R9 high-polarity level in reset", int'(lvl_hi), 1);
    endtask

    task automatic t_powerup();
        int t0, at;
        rst = 1'b0;
        t0 = cyc;
        wait_drive(1'b0, at);
        chk("R2 power-up release edge", at, t0 + HOLD + 2);
        chk("R9 released level low-polarity", int'(lvl), 1);
        chk("R9 released level high-polarity", int'(lvl_hi), 0);
        chk("R9 released drive high-polarity", int'(drv_hi), 0);
    endtask

    task automatic t_stuck_high();
        int t, b, r, at;
        sel = 2'b10;
        t = cyc;
        wait_drive(1'b1, at);
        chk("R5 stuck-high timeout", at, t + PS);
        chk("R9 asserted level low-polarity", int'(lvl), 0);
        b = at;
        wait_drive(1'b0, r);
        chk("R8 watchdog hold length", r, b + HOLD);
        wait_drive(1'b1, at);
        chk("R8 count restarts after release", at, r + PS);
    endtask

    task automatic t_stuck_low();
        int r, at;
        wdi = 1'b0;
        wait_drive(1'b0, r);
        wait_drive(1'b1, at);
        chk("R5 stuck-low timeout", at, r + PS);
    endtask

    task automatic t_periods();
        int r, at;
        sel = 2'b00;
        wait_drive(1'b0, r);
        wait_drive(1'b1, at);
        chk("R7 select 00 long period", at, r + PL);
        sel = 2'b01;
        wait_drive(1'b0, r);
        wait_drive(1'b1, at);
        chk("R7 select 01 mid period", at, r + PM);
    endtask

    task automatic t_kick();
        int r, t, at;
        wdi = 1'b1;
        sel = 2'b10;
        wait_drive(1'b0, r);
        step(4);
        t = cyc;
        wdi = 1'b0;
        wait_drive(1'b1, at);
        chk("R6 falling edge clears count", at, t + 3 + PS);
        wait_drive(1'b0, r);
        step(4);
        wdi = 1'b1;
        wait_drive(1'b1, at);
        chk("R6 rising edge does not clear", at, r + PS);
    endtask

    task automatic t_periodic();
        int r, bad;
        bad = 0;
        wait_drive(1'b0, r);
        for (int k = 0; k < 24; k++) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (drv) bad++;
            end
            wdi = ~wdi;
        end
        chk("R6 periodic kicks keep reset released", bad, 0);
    endtask

    task automatic t_disabled();
        int bad;
        bad = 0;
        sel = 2'b11;
        wdi = 1'b1;
        for (int i = 0; i < 3 * PL; i++) begin
            @(negedge clk);
            if (drv) bad++;
        end
        chk("R7 select 11 disables watchdog", bad, 0);
    endtask

    task automatic t_supply();
        int t, at;
        supply_ok = 1'b0;
        step(2);
        chk("R3 not asserted before edge U+2", int'(drv), 0);
        step(1);
        chk("R3 asserted after edge U+2", int'(drv), 1);
        step(5);
        supply_ok = 1'b1;
        step(10);
        supply_ok = 1'b0;
        step(4);
        chk("R4 still asserted during dip", int'(drv), 1);
        supply_ok = 1'b1;
        t = cyc;
        wait_drive(1'b0, at);
        chk("R4 hold restarts after dip", at, t + HOLD + 2);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_stuck_high();
        t_stuck_low();
        t_periods();
        t_kick();
        t_periodic();
        t_disabled();
        t_supply();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule